// File: doc/BRIEF.md
# Circular Buffer Pointer Controller

This block keeps the bookkeeping for a first-in first-out queue whose storage sits in a region of external memory. A separate writer engine and reader engine move the data. Each engine gives the block a one-cycle strobe for every word it stores or fetches. In return the block tells it which memory address to use next and whether it may go on.

The region starts at a fixed base address and holds a power-of-two number of words. The block keeps one offset for writes and one for reads, each counting round the region. It also keeps a fill level. Two flags are derived from the level:
- The write side may proceed while the level is strictly below a write threshold.
- The read side may proceed while the level is strictly above a read threshold.

With the default thresholds, these flags reduce to "not full" and "not empty". Raising the read threshold makes the reader wait until a batch of words has built up. Lowering the write threshold keeps some headroom in the region.

Top module: `ring_ptr_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the level is 0 and both address outputs equal the base address.
- R2: A sampled write strobe advances the write offset by one modulo the depth. The write address output is the base plus that offset, so after depth writes it returns to the base.
- R3: A sampled read strobe advances the read offset by one modulo the depth. The read address output is the base plus that offset.
- R4: An address change appears on the output one clock after the edge that samples the strobe, so back-to-back strobes produce consecutive addresses in consecutive cycles.
- R5: A write strobe without a read strobe raises the level by one at that clock edge.
- R6: A read strobe without a write strobe lowers the level by one at that clock edge.
- R7: Both strobes in the same cycle leave the level unchanged, while both addresses advance.
- R8: The writable output is 1 exactly when the level is below the write threshold. It is combinational from the level.
- R9: The readable output is 1 exactly when the level is above the read threshold. It is combinational from the level.
- R10: The defaults are a read threshold of 0 and a write threshold equal to the depth. With these, writable is 0 only at a level equal to the depth, and readable is 0 only at level 0.
- R11: In a cycle with neither strobe, the level and both addresses hold their values.
- R12: When writes are issued only while writable is 1 and reads only while readable is 1, the level stays within 0 to depth. It can reach the depth, because the level is one bit wider than an offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One word was written this cycle |
| rd_stb | input | 1 | One word was read this cycle |
| wr_addr | output | ADDR_W | Memory address for the next write |
| rd_addr | output | ADDR_W | Memory address for the next read |
| level | output | clog2(DEPTH)+1 | Words currently held |
| writable | output | 1 | Level below the write threshold |
| readable | output | 1 | Level above the read threshold |

## Verification
Any error in the level is visible at the ports in the cycle after it occurs. It shows first as a wrong level, and then as flags that assert or drop a word too early or too late. An offset that skips or fails to wrap shows on the matching address output one clock after the strobe. It stays wrong from then on, because nothing else corrects it. The bench therefore compares every output after every single cycle, rather than only at the end of a sequence. It drives fill, drain, wrap, simultaneous and idle cycles on two parameter sets, so that each threshold edge is crossed in both directions.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;

  // next offset round a region of 'depth' words
  function automatic int unsigned wrap_inc(int unsigned off, int unsigned depth);
    return (off + 1 == depth) ? 0 : off + 1;
  endfunction

  // fill level after one cycle of strobes
  function automatic int unsigned level_step(int unsigned lvl, logic inc, logic dec);
    case ({inc, dec})
      2'b10:   return lvl + 1;
      2'b01:   return lvl - 1;
      default: return lvl;
    endcase
  endfunction

  function automatic logic under_limit(int unsigned lvl, int unsigned lim);
    return lvl < lim;
  endfunction

  function automatic logic over_limit(int unsigned lvl, int unsigned lim);
    return lvl > lim;
  endfunction

  function automatic int unsigned region_addr(int unsigned base, int unsigned off);
    return base + off;
  endfunction

endpackage

// File: rtl/ring_wrap_ctr.sv
module ring_wrap_ctr
  import ring_ptr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int          IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] off,
  output logic             wrap_evt
);

  logic [IDX_W-1:0] off_q;

  // last slot of the region being consumed this cycle
  assign wrap_evt = step && (32'(off_q) == DEPTH - 1);
  assign off      = off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    off_q <= '0;
    else if (step) off_q <= IDX_W'(wrap_inc(32'(off_q), DEPTH));
  end

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> off_q == '0);

  assert_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> off_q != $past(off_q));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(off_q));

endmodule

// File: rtl/ring_level.sv
module ring_level
  import ring_ptr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int          LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [LVL_W-1:0] level
);

  logic [LVL_W-1:0] lvl_q;

  assign level = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= LVL_W'(level_step(32'(lvl_q), inc, dec));
  end

  assert_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |=> lvl_q == $past(lvl_q) + LVL_W'(1));

  assert_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc) |=> lvl_q == $past(lvl_q) - LVL_W'(1));

  assert_same_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(lvl_q));

  assert_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    32'(lvl_q) <= DEPTH);

endmodule

// File: rtl/ring_flags.sv
module ring_flags
  import ring_ptr_pkg::*;
#(
  parameter int          LVL_W     = 5,
  parameter int unsigned RD_THRESH = 0,
  parameter int unsigned WR_THRESH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  output logic             writable,
  output logic             readable
);

  assign writable = under_limit(32'(level), WR_THRESH);
  assign readable = over_limit(32'(level), RD_THRESH);

  // writable can only drop as the level climbs
  assert_wr_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(writable) |-> level > $past(level));

  // readable can only rise as the level climbs
  assert_rd_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(readable) |-> level > $past(level));

endmodule

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl
  import ring_ptr_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int unsigned BASE      = 0,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned RD_THRESH = 0,
  parameter int unsigned WR_THRESH = DEPTH,
  localparam int         IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int         LVL_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LVL_W-1:0]  level,
  output logic              writable,
  output logic              readable
);

  // index 0: write side, index 1: read side
  logic [1:0]       stb;
  logic [IDX_W-1:0] off [2];
  logic [1:0]       wrap_evt;

  assign stb = {rd_stb, wr_stb};

  for (genvar g = 0; g < 2; g++) begin : g_ptr
    ring_wrap_ctr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (stb[g]),
      .off      (off[g]),
      .wrap_evt (wrap_evt[g])
    );
  end

  assign wr_addr = ADDR_W'(region_addr(BASE, 32'(off[0])));
  assign rd_addr = ADDR_W'(region_addr(BASE, 32'(off[1])));

  ring_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (wr_stb),
    .dec   (rd_stb),
    .level (level)
  );

  ring_flags #(.LVL_W(LVL_W), .RD_THRESH(RD_THRESH), .WR_THRESH(WR_THRESH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (level),
    .writable (writable),
    .readable (readable)
  );

  assert_wr_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt[0] |=> wr_addr == ADDR_W'(BASE));

  assert_rd_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt[1] |=> rd_addr == ADDR_W'(BASE));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !rd_stb) |=> $stable(level) && $stable(wr_addr) && $stable(rd_addr));

endmodule

// File: tb/tb_ring_ptr_ctrl.sv
`timescale 1ns/1ps
module tb_ring_ptr_ctrl;

  localparam int D1 = 16;
  localparam int D2 = 8;
  localparam int B2 = 'h200;
  localparam int RT2 = 2;
  localparam int WT2 = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic wr1 = 1'b0, rd1 = 1'b0, wr2 = 1'b0, rd2 = 1'b0;
  logic [15:0] wa1, ra1, wa2, ra2;
  logic [4:0]  lv1;
  logic [3:0]  lv2;
  logic        wb1, rb1, wb2, rb2;

  ring_ptr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr1), .rd_stb(rd1),
    .wr_addr(wa1), .rd_addr(ra1), .level(lv1), .writable(wb1), .readable(rb1)
  );

  ring_ptr_ctrl #(.BASE(B2), .DEPTH(D2), .RD_THRESH(RT2), .WR_THRESH(WT2)) dut_thr (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr2), .rd_stb(rd2),
    .wr_addr(wa2), .rd_addr(ra2), .level(lv2), .writable(wb2), .readable(rb2)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int m_wo = 0, m_ro = 0, m_lv = 0;
  int n_wo = 0, n_ro = 0, n_lv = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp1();
    chk("R2 R4 write address", int'(wa1), m_wo);
    chk("R3 R4 read address", int'(ra1), m_ro);
    chk("R5 R6 R7 level", int'(lv1), m_lv);
    chk("R8 R10 writable", int'(wb1), int'(m_lv < D1));
    chk("R9 R10 readable", int'(rb1), int'(m_lv > 0));
  endtask

  task automatic cmp2();
    chk("R2 write address with base", int'(wa2), B2 + n_wo);
    chk("R3 read address with base", int'(ra2), B2 + n_ro);
    chk("R5 R6 level", int'(lv2), n_lv);
    chk("R8 writable threshold", int'(wb2), int'(n_lv < WT2));
    chk("R9 readable threshold", int'(rb2), int'(n_lv > RT2));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc1(input bit w, input bit r);
    wr1 = w; rd1 = r;
    @(posedge clk);
    if (w && !r) m_lv++;
    if (r && !w) m_lv--;
    if (w) m_wo = (m_wo + 1) % D1;
    if (r) m_ro = (m_ro + 1) % D1;
    @(negedge clk);
    wr1 = 1'b0; rd1 = 1'b0;
    cmp1();
  endtask

  task automatic cyc2(input bit w, input bit r);
    wr2 = w; rd2 = r;
    @(posedge clk);
    if (w && !r) n_lv++;
    if (r && !w) n_lv--;
    if (w) n_wo = (n_wo + 1) % D2;
    if (r) n_ro = (n_ro + 1) % D2;
    @(negedge clk);
    wr2 = 1'b0; rd2 = 1'b0;
    cmp2();
  endtask

  task automatic t_reset();
    #5;
    chk("R1 level in reset", int'(lv1), 0);
    chk("R1 write address in reset", int'(wa1), 0);
    chk("R1 read address in reset", int'(ra1), 0);
    chk("R1 base address in reset", int'(wa2), B2);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 level after release", int'(lv2), 0);
    chk("R1 read base after release", int'(ra2), B2);
    cmp1(); cmp2();
  endtask

  task automatic t_fill();
    for (int i = 0; i < D1; i++) cyc1(1, 0);
    chk("R12 level reaches depth", int'(lv1), D1);
    chk("R10 writable low only when full", int'(wb1), 0);
    chk("R2 write address back at base", int'(wa1), 0);
  endtask

  task automatic t_part_drain();
    for (int i = 0; i < 10; i++) cyc1(0, 1);
  endtask

  task automatic t_wrap_write();
    for (int i = 0; i < 5; i++) cyc1(1, 0);
    chk("R2 write wrap offset", int'(wa1), 5);
  endtask

  task automatic t_both();
    for (int i = 0; i < 6; i++) cyc1(1, 1);
    chk("R7 level unchanged by paired strobes", int'(lv1), 11);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 3; i++) begin
      cyc1(0, 0);
      chk("R11 level held", int'(lv1), 11);
      chk("R11 write address held", int'(wa1), 11);
    end
  endtask

  task automatic t_drain();
    while (m_lv > 0) cyc1(0, 1);
    chk("R10 readable low when empty", int'(rb1), 0);
    chk("R3 read catches write", int'(ra1), int'(wa1));
  endtask

  task automatic t_read_wrap();
    for (int i = 0; i < 12; i++) cyc1(1, 0);
    for (int i = 0; i < 12; i++) cyc1(0, 1);
    chk("R3 read offset after wrap", int'(ra1), (11 + 12) % D1);
  endtask

  task automatic t_thresh();
    for (int i = 0; i < D2; i++) cyc2(1, 0);
    chk("R12 level at depth", int'(lv2), D2);
    chk("R2 base write wrap", int'(wa2), B2);
    for (int i = 0; i < D2; i++) cyc2(0, 1);
    chk("R9 readable off at zero", int'(rb2), 0);
    for (int i = 0; i < 3; i++) cyc2(1, 1);
    chk("R7 paired strobes at level 0", int'(lv2), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_fill();
    t_part_drain();
    t_wrap_write();
    t_both();
    t_idle();
    t_drain();
    t_read_wrap();
    t_thresh();
    finish_run();
  end

endmodule